// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block merges the receive-side and transmit-side interrupt conditions of a UART into one interrupt request and a 4-bit identification code. It watches the receive error flags, the receive FIFO level against a programmable trigger, a character-timeout pulse from the receiver and the transmit holding register empty status. Each source is latched or evaluated, masked by its own enable bit and passed through a fixed priority encoder. The result is registered, so both outputs change one clock after the edge at which the causing input was sampled.

Each source has its own clear rule, and these rules use strobes that the bus decoder raises:
- a read of the line status register clears the line error interrupt;
- a drop of the FIFO level below the trigger clears the data-available interrupt;
- a read of the receive buffer clears the timeout;
- a read of the identification register clears the transmit-empty interrupt, but only while that interrupt is the one being reported;
- a write to the transmit holding register also clears the transmit-empty interrupt.

Software reads the code to find which source to service.

Top module: `uart_irq_ident`

## Requirements
- R1: After a synchronous reset, `irq` is 0 and `iir_code` is 4'b0001. The transmit-empty edge tracker starts as if the register were already empty, so a high `thr_empty` alone raises nothing.
- R2: `iir_code[0]` is 1 exactly when no enabled source is pending, and `irq` equals the inverse of `iir_code[0]`. Both outputs reflect the inputs sampled at the previous rising clock edge.
- R3: `iir_code` only ever takes one of five values: 0001 (none), 0110 (line error), 0100 (data available), 1100 (timeout) or 0010 (transmit empty).
- R4: Any set bit of `err_flags` latches a line error interrupt. The bits are [0] overrun, [1] parity, [2] framing and [3] break. This interrupt is reported as 0110 ahead of every other source.
- R5: A line error interrupt clears on `rd_lsr`. When a new error flag arrives in the same cycle as `rd_lsr`, the interrupt stays pending.
- R6: Data available (0100) is pending while `rx_level` is at or above the trigger level and deasserts once the level falls below it. `trig_sel` values 0, 1, 2 and 3 select triggers of 1, 4, 8 and 14 characters.
- R7: A `cti_pulse` sampled while `rx_level` is nonzero latches a timeout interrupt (1100), and `rd_rbr` clears it. A pulse while the FIFO is empty is ignored. When data available and timeout are both pending, data available is reported.
- R8: A 0-to-1 transition of `thr_empty` between consecutive clock edges latches a transmit-empty interrupt (0010). This interrupt has the lowest priority.
- R9: The transmit-empty interrupt clears on `wr_thr`, or on `rd_iir` while `iir_code` is showing 0010. An `rd_iir` while another code is shown leaves it pending.
- R10: The enable bits in `ien` are [0] data available, [1] transmit empty, [2] line error and [3] timeout. A disabled source neither raises `irq` nor appears in `iir_code`, but its latched state is kept and shows once the source is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_flags | input | 4 | Receive error events: [0] overrun, [1] parity, [2] framing, [3] break |
| ien | input | 4 | Source enables: [0] data available, [1] transmit empty, [2] line error, [3] timeout |
| rx_level | input | LVL_W | Current receive FIFO fill level |
| trig_sel | input | 2 | Trigger select (1, 4, 8 or 14 characters) |
| cti_pulse | input | 1 | Character timeout event from the receiver |
| thr_empty | input | 1 | Transmit holding register is empty |
| rd_lsr | input | 1 | Strobe: line status register read |
| rd_iir | input | 1 | Strobe: identification register read |
| rd_rbr | input | 1 | Strobe: receive buffer read |
| wr_thr | input | 1 | Strobe: transmit holding register write |
| irq | output | 1 | Interrupt request |
| iir_code | output | 4 | Interrupt identification code |

## Verification
The bench builds the block with `LVL_W` = 5 and triggers of 1, 4, 8 and 14. A 5-bit level reaches 31, so every trigger can be approached from one below, met exactly and exceeded, and levels beyond the deepest trigger are driven as well. With these values the directed part walks each trigger boundary, every priority pairing and the same-cycle set/clear races. A pseudo-random phase then mixes all strobes, enables and levels against the reference model, and the comparison runs on every clock.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam logic [3:0] ID_NONE = 4'b0001;
  localparam logic [3:0] ID_RLS  = 4'b0110;
  localparam logic [3:0] ID_RDA  = 4'b0100;
  localparam logic [3:0] ID_CTI  = 4'b1100;
  localparam logic [3:0] ID_THRE = 4'b0010;

  typedef struct packed {
    logic rls;
    logic rda;
    logic cti;
    logic thre;
  } irq_src_t;
endpackage

// File: rtl/uart_irq_latch.sv
module uart_irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic nxt_o
);
  logic q;

  // a new event outranks a clear arriving in the same cycle
  assign nxt_o = set_i | (q & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= nxt_o;
  end
endmodule

// File: rtl/uart_irq_trig.sv
module uart_irq_trig #(
  parameter int LVL_W = 5,
  parameter int TRIG0 = 1,
  parameter int TRIG1 = 4,
  parameter int TRIG2 = 8,
  parameter int TRIG3 = 14
) (
  input  logic [LVL_W-1:0] rx_level,
  input  logic [1:0]       trig_sel,
  output logic             at_trig
);
  localparam int NTRIG = 4;
  localparam int TRIG_TAB [NTRIG] = '{TRIG0, TRIG1, TRIG2, TRIG3};

  logic [NTRIG-1:0] hit;

  for (genvar i = 0; i < NTRIG; i++) begin : g_cmp
    assign hit[i] = (rx_level >= LVL_W'(TRIG_TAB[i]));
  end

  assign at_trig = hit[trig_sel];
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  irq_src_t   act,
  output logic [3:0] code,
  output logic       any
);
  always_comb begin
    if (act.rls)       code = ID_RLS;
    else if (act.rda)  code = ID_RDA;
    else if (act.cti)  code = ID_CTI;
    else if (act.thre) code = ID_THRE;
    else               code = ID_NONE;
  end

  assign any = |act;
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 5,
  parameter int TRIG0 = 1,
  parameter int TRIG1 = 4,
  parameter int TRIG2 = 8,
  parameter int TRIG3 = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       err_flags,
  input  logic [3:0]       ien,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [1:0]       trig_sel,
  input  logic             cti_pulse,
  input  logic             thr_empty,
  input  logic             rd_lsr,
  input  logic             rd_iir,
  input  logic             rd_rbr,
  input  logic             wr_thr,
  output logic             irq,
  output logic [3:0]       iir_code
);
  logic     rls_nxt, cti_nxt, thre_nxt, rda_nxt;
  logic     thr_q;
  logic     thre_rise, thre_clr, cti_set;
  irq_src_t act;
  logic [3:0] code_nxt;
  logic       any_nxt;

  uart_irq_latch u_rls (
    .clk(clk), .rst(rst),
    .set_i(|err_flags), .clr_i(rd_lsr), .nxt_o(rls_nxt)
  );

  assign cti_set = cti_pulse & (rx_level != '0);

  uart_irq_latch u_cti (
    .clk(clk), .rst(rst),
    .set_i(cti_set), .clr_i(rd_rbr), .nxt_o(cti_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) thr_q <= 1'b1;
    else     thr_q <= thr_empty;
  end

  assign thre_rise = thr_empty & ~thr_q;
  assign thre_clr  = wr_thr | (rd_iir & (iir_code == ID_THRE));

  uart_irq_latch u_thre (
    .clk(clk), .rst(rst),
    .set_i(thre_rise), .clr_i(thre_clr), .nxt_o(thre_nxt)
  );

  uart_irq_trig #(
    .LVL_W(LVL_W), .TRIG0(TRIG0), .TRIG1(TRIG1), .TRIG2(TRIG2), .TRIG3(TRIG3)
  ) u_trig (
    .rx_level(rx_level), .trig_sel(trig_sel), .at_trig(rda_nxt)
  );

  assign act.rls  = rls_nxt  & ien[2];
  assign act.rda  = rda_nxt  & ien[0];
  assign act.cti  = cti_nxt  & ien[3];
  assign act.thre = thre_nxt & ien[1];

  uart_irq_prio u_prio (
    .act(act), .code(code_nxt), .any(any_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iir_code <= ID_NONE;
      irq      <= 1'b0;
    end else begin
      iir_code <= code_nxt;
      irq      <= any_nxt;
    end
  end
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 5,
  parameter int TRIG3 = 14
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       err_flags,
  input logic [3:0]       ien,
  input logic [LVL_W-1:0] rx_level,
  input logic [1:0]       trig_sel,
  input logic             rd_lsr,
  input logic             wr_thr,
  input logic             thr_empty,
  input logic             irq,
  input logic [3:0]       iir_code
);
  a_r3_code_legal: assert property (@(posedge clk) disable iff (rst)
    (iir_code == ID_NONE) || (iir_code == ID_RLS) || (iir_code == ID_RDA) ||
    (iir_code == ID_CTI) || (iir_code == ID_THRE));

  a_r2_irq_matches_code: assert property (@(posedge clk) disable iff (rst)
    irq == !iir_code[0]);

  a_r4_rls_on_top: assert property (@(posedge clk) disable iff (rst)
    ((|err_flags) && ien[2]) |=> (iir_code == ID_RLS));

  a_r5_rls_cleared: assert property (@(posedge clk) disable iff (rst)
    (rd_lsr && !(|err_flags)) |=> (iir_code != ID_RLS));

  a_r6_rda_deepest: assert property (@(posedge clk) disable iff (rst)
    ((ien == 4'b0001) && (trig_sel == 2'd3) && (rx_level >= LVL_W'(TRIG3)))
      |=> (iir_code == ID_RDA));

  a_r9_thre_written: assert property (@(posedge clk) disable iff (rst)
    (wr_thr && !thr_empty) |=> (iir_code != ID_THRE));

  a_r10_all_masked: assert property (@(posedge clk) disable iff (rst)
    (ien == 4'b0000) |=> !irq);
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.LVL_W(LVL_W), .TRIG3(TRIG3)) u_chk (
  .clk(clk), .rst(rst), .err_flags(err_flags), .ien(ien), .rx_level(rx_level),
  .trig_sel(trig_sel), .rd_lsr(rd_lsr), .wr_thr(wr_thr), .thr_empty(thr_empty),
  .irq(irq), .iir_code(iir_code)
);

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
  localparam int CLK_P = 10;
  localparam int LW    = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    err_flags = '0;
  logic [3:0]    ien = '0;
  logic [LW-1:0] rx_level = '0;
  logic [1:0]    trig_sel = '0;
  logic cti_pulse = 0, thr_empty = 1, rd_lsr = 0, rd_iir = 0, rd_rbr = 0, wr_thr = 0;
  logic          irq;
  logic [3:0]    iir_code;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model state
  bit m_rls, m_cti, m_thre, m_prev_te;
  logic [3:0] e_iir = 4'b0001;
  logic       e_irq = 1'b0;

  uart_irq_ident #(.LVL_W(LW)) u0 (
    .clk(clk), .rst(rst), .err_flags(err_flags), .ien(ien), .rx_level(rx_level),
    .trig_sel(trig_sel), .cti_pulse(cti_pulse), .thr_empty(thr_empty),
    .rd_lsr(rd_lsr), .rd_iir(rd_iir), .rd_rbr(rd_rbr), .wr_thr(wr_thr),
    .irq(irq), .iir_code(iir_code)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int trig_chars(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic model_edge();
    bit rda;
    if (rst) begin
      m_rls = 0; m_cti = 0; m_thre = 0; m_prev_te = 1;
      e_iir = 4'b0001; e_irq = 0;
    end else begin
      if (err_flags != 0) m_rls = 1; else if (rd_lsr) m_rls = 0;
      if (cti_pulse && rx_level != 0) m_cti = 1; else if (rd_rbr) m_cti = 0;
      if (thr_empty && !m_prev_te) m_thre = 1;
      else if (wr_thr || (rd_iir && e_iir == 4'b0010)) m_thre = 0;
      m_prev_te = thr_empty;
      rda = (int'(rx_level) >= trig_chars(trig_sel));
      if (m_rls && ien[2])       e_iir = 4'b0110;
      else if (rda && ien[0])    e_iir = 4'b0100;
      else if (m_cti && ien[3])  e_iir = 4'b1100;
      else if (m_thre && ien[1]) e_iir = 4'b0010;
      else                       e_iir = 4'b0001;
      e_irq = (e_iir != 4'b0001);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    checks++;
    if (iir_code !== e_iir || irq !== e_irq) begin
      failures++;
      $display("FAIL %s: iir_code=%b expected=%b irq=%b expected=%b",
               tag, iir_code, e_iir, irq, e_irq);
    end
    err_flags = '0; cti_pulse = 0; rd_lsr = 0; rd_iir = 0; rd_rbr = 0; wr_thr = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    @(negedge clk);
    step("R1 reset"); step("R1 reset");
    rst = 0;
    step("R1 idle after reset, thr_empty high");

    // R6: trigger boundaries
    ien = 4'b0001;
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      rx_level = LW'(trig_chars(2'(s)) - 1); step("R6 below trigger");
      rx_level = LW'(trig_chars(2'(s)));     step("R6 at trigger");
      rx_level = LW'(trig_chars(2'(s)) + 1); step("R6 above trigger");
      rx_level = LW'(trig_chars(2'(s)) - 1); step("R6 drop below trigger");
    end
    rx_level = 5'd31; step("R6 level beyond deepest trigger");

    // R4/R5: each error bit, priority over RDA, clear rules
    ien = 4'b1111;
    for (int b = 0; b < 4; b++) begin
      err_flags = 4'(1 << b); step("R4 error bit sets line interrupt");
      step("R4 line interrupt held");
      rd_lsr = 1; step("R5 status read clears");
    end
    err_flags = 4'b0100; step("R4");
    rd_lsr = 1; err_flags = 4'b0001; step("R5 new error with status read keeps pending");
    rd_lsr = 1; step("R5 clears");

    // R7: timeout
    trig_sel = 2'd3; rx_level = 5'd0;
    cti_pulse = 1; step("R7 timeout ignored with empty FIFO");
    rx_level = 5'd2; cti_pulse = 1; step("R7 timeout latched");
    rx_level = 5'd14; step("R7 data available reported ahead of timeout");
    rx_level = 5'd13; step("R7 timeout visible again");
    rd_rbr = 1; cti_pulse = 1; step("R7 set wins over receive read");
    rd_rbr = 1; step("R7 receive read clears");

    // R8/R9: transmit empty
    thr_empty = 0; step("R8 register filled");
    thr_empty = 1; step("R8 rising empty raises 0010");
    rd_iir = 1; step("R9 id read while shown clears");
    thr_empty = 0; step("R8");
    thr_empty = 1; rx_level = 5'd14; step("R8 lowest priority under data available");
    rd_iir = 1; step("R9 id read while other code shown keeps pending");
    rx_level = 5'd3; step("R9 transmit empty now shown");
    wr_thr = 1; thr_empty = 0; step("R9 write clears");
    thr_empty = 1; step("R8");

    // R10: masking keeps state
    ien = 4'b0000; step("R10 all masked");
    err_flags = 4'b1000; step("R10 masked line error invisible");
    ien = 4'b0100; step("R10 enabling reveals latched line error");
    ien = 4'b0010; step("R10 transmit empty revealed");
    ien = 4'b1111; rd_lsr = 1; step("R2");

    // R2/R3: mixed pseudo-random traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      err_flags = (lfsr[3:0] == 4'hF) ? lfsr[7:4] : 4'h0;
      rx_level  = LW'(lfsr[12:8] % 18);
      trig_sel  = lfsr[14:13];
      cti_pulse = (lfsr[6:4] == 3'd5);
      thr_empty = lfsr[15] | lfsr[1];
      rd_lsr    = (lfsr[2:0] == 3'd1);
      rd_iir    = lfsr[9] & lfsr[11];
      rd_rbr    = (lfsr[5:3] == 3'd2);
      wr_thr    = (lfsr[3:1] == 3'd6);
      if (i % 97 == 0) ien = lfsr[7:4];
      step("R2 R3 mixed traffic");
    end

    rst = 1; step("R1 reset again");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule